// File: doc/BRIEF.md
# Write-Before-Read Register File

A 16-entry, 32-bit architectural register file for the operand stage of a five-stage pipeline. It has one write port, driven by the write-back stage, and two read ports. Read port B is addressed by one operand field of the instruction in decode, and read port C by the other. The write-back stage delivers a destination index, a result word and the 6-bit major opcode of the retiring instruction. The top bit of that opcode is the write enable.

A value written in a cycle must be seen by a read of the same register in that same cycle. This matches a write in the first half of the cycle and reads in the second half. The block implements it in a single-edge design: each read port compares its index with the write index. On a match while writing is enabled, the port returns the incoming write data combinationally instead of the stored word. Storage is flops with an asynchronous active-low reset that clears every register to zero. Register 0 has no special meaning and is written like any other.

Top module: `wbr_regfile`

## Requirements
- R1: After reset every register reads as zero on both read ports.
- R2: A write takes place only when bit 5 (the most significant bit) of `wb_op_i` is 1. With that bit at 0, no register changes, whatever the other five opcode bits, the index or the data.
- R3: A write enabled at a rising clock edge stores `wb_data_i` at index `wb_addr_i`. From the next cycle it reads back on both ports.
- R4: During a cycle in which a write is enabled and `rd_b_addr_i` equals `wb_addr_i`, `rd_b_data_o` equals `wb_data_i` in that same cycle.
- R5: During a cycle in which a write is enabled and `rd_c_addr_i` equals `wb_addr_i`, `rd_c_data_o` equals `wb_data_i` in that same cycle.
- R6: Register 0 is an ordinary register. It stores and returns any written value, nonzero values included.
- R7: A write changes only the addressed register. All other registers keep their contents.
- R8: The two read ports are independent. Any pair of indices, equal or different, returns the stored contents of each addressed register at the same time.
- R9: When the write is disabled (opcode bit 5 is 0), a read of the index on `wb_addr_i` returns the stored word, not `wb_data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes occur on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all registers |
| wb_op_i | input | 6 | Major opcode from write-back; bit 5 enables the write |
| wb_addr_i | input | 4 | Destination register index from write-back |
| wb_data_i | input | 32 | Result word from write-back |
| rd_b_addr_i | input | 4 | Read port B register index |
| rd_c_addr_i | input | 4 | Read port C register index |
| rd_b_data_o | output | 32 | Read port B data, bypassed on a same-cycle write |
| rd_c_data_o | output | 32 | Read port C data, bypassed on a same-cycle write |

## Verification
The assertions assume that the inputs are stable around each rising edge. They also assume that, between edges, a read with no matching enabled write reflects storage only. Their properties compare one cycle's write with the next cycle's read, so they rely on the read index being held or changed only at the inactive clock edge. The stimulus changes every input at the falling edge, so both the combinational bypass and the stored value are observed half a cycle later. The stimulus sweeps every register and every pair of read indices against a model array kept in the bench.

// File: rtl/wbr_regfile_pkg.sv
package wbr_regfile_pkg;
  localparam int unsigned NREGS_DEF = 16;
  localparam int unsigned DW_DEF    = 32;
  localparam int unsigned OPW_DEF   = 6;
  localparam int unsigned NRD       = 2;  // read ports: 0 = B, 1 = C
  typedef enum logic [0:0] {RD_B = 1'b0, RD_C = 1'b1} rd_port_e;
endpackage

// File: rtl/wbr_we_decode.sv
module wbr_we_decode #(
  parameter int unsigned OPW = 6
) (
  input  logic [OPW-1:0] op_i,
  output logic           we_o
);
  localparam int unsigned WE_BIT = OPW - 1;
  assign we_o = op_i[WE_BIT];
endmodule

// File: rtl/wbr_store.sv
module wbr_store #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              waddr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NREGS-1:0][DW-1:0]   regs_o
);
  logic [NREGS-1:0][DW-1:0] mem_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (we_i && (waddr_i == AW'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  assign regs_o = mem_q;
endmodule

// File: rtl/wbr_read_port.sv
module wbr_read_port #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][DW-1:0] regs_i,
  input  logic [AW-1:0]            raddr_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o
);
  logic hit;
  // same-cycle write wins: stands in for write-first-half, read-second-half
  assign hit     = we_i && (waddr_i == raddr_i);
  assign rdata_o = hit ? wdata_i : regs_i[raddr_i];
endmodule

// File: rtl/wbr_regfile.sv
module wbr_regfile
  import wbr_regfile_pkg::*;
#(
  parameter int unsigned NREGS = NREGS_DEF,
  parameter int unsigned DW    = DW_DEF,
  parameter int unsigned OPW   = OPW_DEF,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] wb_op_i,
  input  logic [AW-1:0]  wb_addr_i,
  input  logic [DW-1:0]  wb_data_i,
  input  logic [AW-1:0]  rd_b_addr_i,
  input  logic [AW-1:0]  rd_c_addr_i,
  output logic [DW-1:0]  rd_b_data_o,
  output logic [DW-1:0]  rd_c_data_o
);
  logic                     we;
  logic [NREGS-1:0][DW-1:0] regs;
  logic [NRD-1:0][AW-1:0]   raddr;
  logic [NRD-1:0][DW-1:0]   rdata;

  wbr_we_decode #(.OPW(OPW)) u_dec (
    .op_i (wb_op_i),
    .we_o (we)
  );

  wbr_store #(.NREGS(NREGS), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (wb_addr_i),
    .wdata_i (wb_data_i),
    .regs_o  (regs)
  );

  assign raddr[RD_B] = rd_b_addr_i;
  assign raddr[RD_C] = rd_c_addr_i;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    wbr_read_port #(.NREGS(NREGS), .DW(DW)) u_port (
      .regs_i  (regs),
      .raddr_i (raddr[p]),
      .we_i    (we),
      .waddr_i (wb_addr_i),
      .wdata_i (wb_data_i),
      .rdata_o (rdata[p])
    );
  end

  assign rd_b_data_o = rdata[RD_B];
  assign rd_c_data_o = rdata[RD_C];
endmodule

// File: rtl/wbr_regfile_chk.sv
module wbr_regfile_chk #(
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 4,
  parameter int unsigned OPW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [OPW-1:0] wb_op_i,
  input logic [AW-1:0]  wb_addr_i,
  input logic [DW-1:0]  wb_data_i,
  input logic [AW-1:0]  rd_b_addr_i,
  input logic [AW-1:0]  rd_c_addr_i,
  input logic [DW-1:0]  rd_b_data_o,
  input logic [DW-1:0]  rd_c_data_o
);
  localparam int unsigned WB = OPW - 1;

  a_r4_b_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_op_i[WB] && (rd_b_addr_i == wb_addr_i)) |-> (rd_b_data_o == wb_data_i));

  a_r5_c_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_op_i[WB] && (rd_c_addr_i == wb_addr_i)) |-> (rd_c_data_o == wb_data_i));

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_op_i[WB] |=> ((rd_b_addr_i != $past(wb_addr_i)) ||
                     (wb_op_i[WB] && (wb_addr_i == rd_b_addr_i)) ||
                     (rd_b_data_o == $past(wb_data_i))));

  a_r2_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_op_i[WB] |=> ((rd_c_addr_i != $past(rd_c_addr_i)) ||
                      (wb_op_i[WB] && (wb_addr_i == rd_c_addr_i)) ||
                      $stable(rd_c_data_o)));

  a_r8_same_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == rd_c_addr_i) |-> (rd_b_data_o == rd_c_data_o));
endmodule

bind wbr_regfile wbr_regfile_chk #(.DW(DW), .AW(AW), .OPW(OPW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wb_op_i     (wb_op_i),
  .wb_addr_i   (wb_addr_i),
  .wb_data_i   (wb_data_i),
  .rd_b_addr_i (rd_b_addr_i),
  .rd_c_addr_i (rd_c_addr_i),
  .rd_b_data_o (rd_b_data_o),
  .rd_c_data_o (rd_c_data_o)
);

// File: tb/wbr_regfile_test.sv
module wbr_regfile_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  wb_op_i = '0;
  logic [3:0]  wb_addr_i = '0;
  logic [31:0] wb_data_i = '0;
  logic [3:0]  rd_b_addr_i = '0;
  logic [3:0]  rd_c_addr_i = '0;
  logic [31:0] rd_b_data_o, rd_c_data_o;

  logic [31:0] model [16];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wbr_regfile uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [31:0] pat(int i, int k);
    return 32'h9E37_79B9 * (i + 1) ^ (32'h0101_0101 * k) ^ 32'h8000_0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 time unit later
  task automatic drive(logic [5:0] op, int wa, logic [31:0] wd, int ba, int ca);
    @(negedge clk_i);
    wb_op_i = op; wb_addr_i = 4'(wa); wb_data_i = wd;
    rd_b_addr_i = 4'(ba); rd_c_addr_i = 4'(ca);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state on both ports
    for (int i = 0; i < 16; i++) begin
      drive(6'h00, 0, '0, i, 15 - i);
      chk("R1 b", rd_b_data_o, 32'h0);
      chk("R1 c", rd_c_data_o, 32'h0);
    end

    // R3/R4/R5/R6: enabled writes with varied low opcode bits, bypass in-cycle
    for (int i = 0; i < 16; i++) begin
      drive(6'h20 | 6'(i), i, pat(i, 0), i, i);
      chk("R4 bypass b", rd_b_data_o, pat(i, 0));
      chk("R5 bypass c", rd_c_data_o, pat(i, 0));
      model[i] = pat(i, 0);
      drive(6'h00, (i + 1) % 16, 32'hDEAD_BEEF, i, i);
      chk(i == 0 ? "R6 reg0" : "R3 stored b", rd_b_data_o, model[i]);
      chk("R3 stored c", rd_c_data_o, model[i]);
    end

    // R2/R9: disabled writes across all low-bit opcode patterns
    for (int k = 0; k < 32; k++) begin
      int a = k % 16;
      drive(6'(k), a, ~model[a], a, a);
      chk("R9 no bypass b", rd_b_data_o, model[a]);
      chk("R9 no bypass c", rd_c_data_o, model[a]);
      drive(6'h00, (a + 3) % 16, '0, a, (a + 5) % 16);
      chk("R2 unchanged", rd_b_data_o, model[a]);
      chk("R2 other", rd_c_data_o, model[(a + 5) % 16]);
    end

    // R7: write one register, others intact
    drive(6'h3F, 7, 32'h0000_0000, 0, 1);
    model[7] = 32'h0;
    for (int i = 0; i < 16; i++) begin
      drive(6'h00, 0, '0, i, i);
      chk("R7 isolation", rd_b_data_o, model[i]);
    end

    // R8: every read index pair
    for (int b = 0; b < 16; b++) begin
      for (int c = 0; c < 16; c++) begin
        drive(6'h1F, b, 32'hFFFF_FFFF, b, c);
        chk("R8 port b", rd_b_data_o, model[b]);
        chk("R8 port c", rd_c_data_o, model[c]);
      end
    end

    // R6: register 0 overwritten with a second nonzero value
    drive(6'h20, 0, 32'h1234_5678, 3, 0);
    chk("R5 reg0 bypass", rd_c_data_o, 32'h1234_5678);
    chk("R7 neighbour", rd_b_data_o, model[3]);
    model[0] = 32'h1234_5678;
    drive(6'h00, 0, '0, 0, 0);
    chk("R6 reg0 held", rd_b_data_o, 32'h1234_5678);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule